// File: doc/BRIEF.md
# Timing-Qualified Opcode Decode Array

This block decodes the 8-bit instruction register of a small microprocessor into a vector of decode lines. Each line comes from one or more product terms. A product term tests every opcode bit in true form, in complemented form, or not at all. It is also tied to one machine-cycle step, or to none. A line fires while the held opcode matches one of its terms and the current step is that term's step. One line also has an inhibit term: a term that drives no line of its own and forces its target line low while it matches.

The instruction register loads from `ir_d` on any clock where `ir_we` is high. A one-hot step counter covers steps T0 to T5 so that the array can be exercised on its own. The decode lines are purely combinational from the held opcode and the step counter. Random logic further down the chip turns these lines into datapath controls.

Top module: `opdec_array`

## Requirements
- R1: While `rst` is high, `tstep` is 6'b000001 (T0) and the held opcode is 8'h00. The `lines` output then decodes opcode 00 at T0, so only bits 16 and 17 are high.
- R2: The held opcode takes `ir_d` at a clock edge where `ir_we` is high. When `ir_we` is low, it keeps its value whatever `ir_d` carries.
- R3: `tstep` bit k means step Tk. Each clock moves the step one bit up, and T5 wraps to T0. A high `eoi` at a clock edge forces T0 on the next cycle and takes precedence over advancing.
- R4: Bit 0 is high for opcodes 0X001000 at T0 only, and bit 1 is high for opcodes 0X101000 at T3 only. The patterns are written MSB first, with X meaning don't-care.
- R5: For opcodes XXX100X1, bits 2, 3, 4 and 5 are high at T2, T3, T4 and T5 respectively.
- R6: For opcode 00000000, bits 6, 7 and 8 are high at T2, T4 and T5 respectively. For opcode 00100000, bits 9, 10, 11 and 12 are high at T0, T2, T3 and T5 respectively.
- R7: Bit 13 is high for X11XXXX1 at T0. Bit 14 is high at T1 when the opcode matches any one of X11XXXX1, 0XXXXXX1 or 0XX0101X.
- R8: Three lines ignore the step: bit 15 (100XXXXX), bit 16 (X0XXXXXX) and bit 17 (0XXXXXXX).
- R9: Bit 18 is high for XXXX10X0 at any step, except when the opcode also matches 0XX01000.
- R10: `tstep` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ir_d | input | 8 | Opcode to load into the instruction register |
| ir_we | input | 1 | Load enable for the instruction register |
| eoi | input | 1 | End of instruction: return the step to T0 |
| tstep | output | 6 | One-hot current step, bit k = Tk |
| lines | output | 19 | Decode lines |

## Verification
The step counter and the opcode register are the only state. So every input applied before a rising edge shows up in `tstep` and `lines` exactly one clock later, and no further delay follows, because the array itself is combinational. The driver applies inputs at the falling edge. At the same moment it pushes the expected step and line vector for the state after the next rising edge. The monitor pops that entry 5 ns after the rising edge and compares it. The run loads each of the 256 opcodes and walks it through all six steps. Directed runs cover wrap-around, an early `eoi` and a hold with a different `ir_d`.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int IR_W   = 8;
    localparam int NSTEP  = 6;
    localparam int NTERM  = 22;
    localparam int NLINE  = 19;
    localparam int LINE_W = $clog2(NLINE);

    typedef enum logic [2:0] {
        STEP0, STEP1, STEP2, STEP3, STEP4, STEP5, STEP_ANY
    } step_sel_e;

    typedef enum logic {
        ROLE_DRIVE,
        ROLE_INHIBIT
    } term_role_e;

    typedef struct packed {
        logic [IR_W-1:0]   care;
        logic [IR_W-1:0]   val;
        step_sel_e         step;
        term_role_e        role;
        logic [LINE_W-1:0] dst;
    } term_t;

    // decode line indices
    localparam int L_PUSH_T0   = 0;
    localparam int L_PULL_T3   = 1;
    localparam int L_INDY_T2   = 2;
    localparam int L_INDY_T3   = 3;
    localparam int L_INDY_T4   = 4;
    localparam int L_INDY_T5   = 5;
    localparam int L_BRK_T2    = 6;
    localparam int L_BRK_T4    = 7;
    localparam int L_BRK_T5    = 8;
    localparam int L_CALL_T0   = 9;
    localparam int L_CALL_T2   = 10;
    localparam int L_CALL_T3   = 11;
    localparam int L_CALL_T5   = 12;
    localparam int L_ADDSUB_T0 = 13;
    localparam int L_ALU_T1    = 14;
    localparam int L_RANGE_80  = 15;
    localparam int L_RANGE_B6  = 16;
    localparam int L_RANGE_LO  = 17;
    localparam int L_FLAG      = 18;

    function automatic term_t mk_term(input logic [IR_W-1:0] care,
                                      input logic [IR_W-1:0] val,
                                      input step_sel_e step,
                                      input term_role_e role,
                                      input int dst);
        term_t t;
        t.care = care;
        t.val  = val;
        t.step = step;
        t.role = role;
        t.dst  = LINE_W'(dst);
        return t;
    endfunction

    // product-term table: care mask, value, step, role, target line
    function automatic term_t term_at(input int idx);
        term_t t;
        case (idx)
            0:  t = mk_term(8'hBF, 8'h08, STEP0,    ROLE_DRIVE,   L_PUSH_T0);
            1:  t = mk_term(8'hBF, 8'h28, STEP3,    ROLE_DRIVE,   L_PULL_T3);
            2:  t = mk_term(8'h1D, 8'h11, STEP2,    ROLE_DRIVE,   L_INDY_T2);
            3:  t = mk_term(8'h1D, 8'h11, STEP3,    ROLE_DRIVE,   L_INDY_T3);
            4:  t = mk_term(8'h1D, 8'h11, STEP4,    ROLE_DRIVE,   L_INDY_T4);
            5:  t = mk_term(8'h1D, 8'h11, STEP5,    ROLE_DRIVE,   L_INDY_T5);
            6:  t = mk_term(8'hFF, 8'h00, STEP2,    ROLE_DRIVE,   L_BRK_T2);
            7:  t = mk_term(8'hFF, 8'h00, STEP4,    ROLE_DRIVE,   L_BRK_T4);
            8:  t = mk_term(8'hFF, 8'h00, STEP5,    ROLE_DRIVE,   L_BRK_T5);
            9:  t = mk_term(8'hFF, 8'h20, STEP0,    ROLE_DRIVE,   L_CALL_T0);
            10: t = mk_term(8'hFF, 8'h20, STEP2,    ROLE_DRIVE,   L_CALL_T2);
            11: t = mk_term(8'hFF, 8'h20, STEP3,    ROLE_DRIVE,   L_CALL_T3);
            12: t = mk_term(8'hFF, 8'h20, STEP5,    ROLE_DRIVE,   L_CALL_T5);
            13: t = mk_term(8'h61, 8'h61, STEP0,    ROLE_DRIVE,   L_ADDSUB_T0);
            14: t = mk_term(8'h61, 8'h61, STEP1,    ROLE_DRIVE,   L_ALU_T1);
            15: t = mk_term(8'h81, 8'h01, STEP1,    ROLE_DRIVE,   L_ALU_T1);
            16: t = mk_term(8'h9E, 8'h0A, STEP1,    ROLE_DRIVE,   L_ALU_T1);
            17: t = mk_term(8'hE0, 8'h80, STEP_ANY, ROLE_DRIVE,   L_RANGE_80);
            18: t = mk_term(8'h40, 8'h00, STEP_ANY, ROLE_DRIVE,   L_RANGE_B6);
            19: t = mk_term(8'h80, 8'h00, STEP_ANY, ROLE_DRIVE,   L_RANGE_LO);
            20: t = mk_term(8'h0D, 8'h08, STEP_ANY, ROLE_DRIVE,   L_FLAG);
            21: t = mk_term(8'h9F, 8'h08, STEP_ANY, ROLE_INHIBIT, L_FLAG);
            default: t = mk_term(8'h00, 8'h00, STEP_ANY, ROLE_INHIBIT, 0);
        endcase
        return t;
    endfunction

    // which terms feed a given line, by role
    function automatic logic [NTERM-1:0] term_mask(input int line, input term_role_e role);
        logic [NTERM-1:0] m;
        term_t t;
        m = '0;
        for (int i = 0; i < NTERM; i++) begin
            t = term_at(i);
            if (t.role == role && int'(t.dst) == line) begin
                m[i] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/opdec_step_seq.sv
module opdec_step_seq
    import opdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             eoi,
    output logic [NSTEP-1:0] tstep
);

    localparam logic [NSTEP-1:0] FIRST_STEP = NSTEP'(1);

    always_ff @(posedge clk) begin
        if (rst || eoi) begin
            tstep <= FIRST_STEP;
        end else begin
            tstep <= {tstep[NSTEP-2:0], tstep[NSTEP-1]};
        end
    end

endmodule

// File: rtl/opdec_and_plane.sv
module opdec_and_plane
    import opdec_pkg::*;
(
    input  logic [IR_W-1:0]  ir,
    input  logic [NSTEP-1:0] tstep,
    output logic [NTERM-1:0] hit
);

    for (genvar g = 0; g < NTERM; g++) begin : g_term
        localparam term_t TD = term_at(g);
        logic op_ok;
        assign op_ok = ((ir ^ TD.val) & TD.care) == '0;
        if (TD.step == STEP_ANY) begin : g_free
            assign hit[g] = op_ok;
        end else begin : g_timed
            assign hit[g] = op_ok & tstep[int'(TD.step)];
        end
    end

endmodule

// File: rtl/opdec_or_plane.sv
module opdec_or_plane
    import opdec_pkg::*;
(
    input  logic [NTERM-1:0] hit,
    output logic [NLINE-1:0] lines
);

    for (genvar l = 0; l < NLINE; l++) begin : g_line
        localparam logic [NTERM-1:0] DRV_M = term_mask(l, ROLE_DRIVE);
        localparam logic [NTERM-1:0] INH_M = term_mask(l, ROLE_INHIBIT);
        assign lines[l] = (|(hit & DRV_M)) & ~(|(hit & INH_M));
    end

endmodule

// File: rtl/opdec_array.sv
module opdec_array
    import opdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IR_W-1:0]  ir_d,
    input  logic             ir_we,
    input  logic             eoi,
    output logic [NSTEP-1:0] tstep,
    output logic [NLINE-1:0] lines
);

    logic [IR_W-1:0]  ir_q;
    logic [NTERM-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q <= '0;
        end else if (ir_we) begin
            ir_q <= ir_d;
        end
    end

    opdec_step_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .eoi   (eoi),
        .tstep (tstep)
    );

    opdec_and_plane u_and (
        .ir    (ir_q),
        .tstep (tstep),
        .hit   (hit)
    );

    opdec_or_plane u_or (
        .hit   (hit),
        .lines (lines)
    );

endmodule

// File: rtl/opdec_array_chk.sv
module opdec_array_chk
    import opdec_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [IR_W-1:0]  ir_d,
    input logic             ir_we,
    input logic             eoi,
    input logic [IR_W-1:0]  ir_q,
    input logic [NSTEP-1:0] tstep,
    input logic [NLINE-1:0] lines
);

    AST_IR_LOAD: assert property (@(posedge clk) disable iff (rst)
        ir_we |=> ir_q == $past(ir_d)); // R2

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ir_we |=> $stable(ir_q)); // R2

    AST_EOI_FIRST: assert property (@(posedge clk) disable iff (rst)
        eoi |=> tstep == NSTEP'(1)); // R3

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!eoi && !tstep[NSTEP-1]) |=> tstep == ($past(tstep) << 1)); // R3

    AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(tstep) == 1); // R10

    AST_LINES_KNOWN: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(lines)); // R4

    AST_BRK_STEP: assert property (@(posedge clk) disable iff (rst)
        lines[L_BRK_T2] |-> (tstep[2] && ir_q == 8'h00)); // R6

    AST_ALU_T1_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (tstep[1] && (ir_q ==? 8'b0??0101?)) |-> lines[L_ALU_T1]); // R7

    AST_FLAG_MASK: assert property (@(posedge clk) disable iff (rst)
        (ir_q ==? 8'b0??01000) |-> !lines[L_FLAG]); // R9

endmodule

bind opdec_array opdec_array_chk chk_i (.*);

// File: tb/opdec_array_tb_top.sv
module opdec_array_tb_top;
    import opdec_pkg::*;

    typedef struct {
        string            tag;
        logic [NSTEP-1:0] t;
        logic [NLINE-1:0] ln;
    } exp_item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [IR_W-1:0]  ir_d = '0;
    logic             ir_we = 1'b0;
    logic             eoi = 1'b0;
    logic [NSTEP-1:0] tstep;
    logic [NLINE-1:0] lines;

    int checks = 0;
    int errors = 0;
    exp_item_t sb_q[$];
    logic [IR_W-1:0] m_ir = '0;
    int m_step = 0;

    always #10 clk = ~clk;

    opdec_array dut_i (
        .clk   (clk),
        .rst   (rst),
        .ir_d  (ir_d),
        .ir_we (ir_we),
        .eoi   (eoi),
        .tstep (tstep),
        .lines (lines)
    );

    function automatic logic [NLINE-1:0] ref_lines(input logic [7:0] op, input int s);
        logic [NLINE-1:0] r;
        r = '0;
        r[0]  = (op ==? 8'b0?001000) && s == 0;
        r[1]  = (op ==? 8'b0?101000) && s == 3;
        r[2]  = (op ==? 8'b???100?1) && s == 2;
        r[3]  = (op ==? 8'b???100?1) && s == 3;
        r[4]  = (op ==? 8'b???100?1) && s == 4;
        r[5]  = (op ==? 8'b???100?1) && s == 5;
        r[6]  = op == 8'h00 && s == 2;
        r[7]  = op == 8'h00 && s == 4;
        r[8]  = op == 8'h00 && s == 5;
        r[9]  = op == 8'h20 && s == 0;
        r[10] = op == 8'h20 && s == 2;
        r[11] = op == 8'h20 && s == 3;
        r[12] = op == 8'h20 && s == 5;
        r[13] = (op ==? 8'b?11????1) && s == 0;
        r[14] = s == 1 && ((op ==? 8'b?11????1) || (op ==? 8'b0??????1) || (op ==? 8'b0??0101?));
        r[15] = (op ==? 8'b100?????);
        r[16] = (op ==? 8'b?0??????);
        r[17] = (op ==? 8'b0???????);
        r[18] = (op ==? 8'b????10?0) && !(op ==? 8'b0??01000);
        return r;
    endfunction

    function automatic string line_tag(input int l);
        if (l <= 1)  return "R4";
        if (l <= 5)  return "R5";
        if (l <= 12) return "R6";
        if (l <= 14) return "R7";
        if (l <= 17) return "R8";
        return "R9";
    endfunction

    task automatic check_now(input string tag, input logic [NSTEP-1:0] et,
                             input logic [NLINE-1:0] eln);
        checks++;
        if (tstep !== et) begin
            errors++;
            $display("FAIL %s tstep act=%b exp=%b", tag, tstep, et);
        end
        checks++;
        if ($countones(tstep) != 1) begin
            errors++;
            $display("FAIL R10 onehot act=%b exp=one bit set", tstep);
        end
        for (int l = 0; l < NLINE; l++) begin
            checks++;
            if (lines[l] !== eln[l]) begin
                errors++;
                $display("FAIL %s line %0d op=%h step=%0d act=%b exp=%b",
                         line_tag(l), l, m_ir, m_step, lines[l], eln[l]);
            end
        end
    endtask

    // driver: apply inputs at the falling edge, queue the state due after the next rise
    task automatic drive(input logic [7:0] op, input logic we, input logic e, input string tag);
        exp_item_t it;
        @(negedge clk);
        rst   = 1'b0;
        ir_d  = op;
        ir_we = we;
        eoi   = e;
        if (we) m_ir = op;
        m_step = e ? 0 : (m_step + 1) % NSTEP;
        it.tag = tag;
        it.t   = NSTEP'(1) << m_step;
        it.ln  = ref_lines(m_ir, m_step);
        sb_q.push_back(it);
    endtask

    // monitor
    initial begin
        exp_item_t it;
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check_now(it.tag, it.t, it.ln);
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=timeout exp=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now("R1", NSTEP'(1), ref_lines(8'h00, 0));

        // full sweep: every opcode through T0..T5
        for (int op = 0; op < 256; op++) begin
            drive(8'(op), 1'b1, 1'b1, "R2");
            for (int s = 1; s < NSTEP; s++) begin
                drive(8'(255 - op), 1'b0, 1'b0, "R3");
            end
        end

        // wrap from T5 to T0 with the register holding against a new ir_d
        drive(8'h20, 1'b1, 1'b1, "R3");
        for (int s = 1; s < NSTEP; s++) drive(8'hAA, 1'b0, 1'b0, "R3");
        drive(8'h48, 1'b0, 1'b0, "R3");
        drive(8'h68, 1'b0, 1'b0, "R2");

        // early end of instruction at T2
        drive(8'h11, 1'b1, 1'b1, "R3");
        drive(8'h00, 1'b0, 1'b0, "R3");
        drive(8'h00, 1'b0, 1'b0, "R3");
        drive(8'h00, 1'b0, 1'b1, "R3");
        drive(8'h08, 1'b1, 1'b0, "R9");
        drive(8'h18, 1'b1, 1'b0, "R9");

        repeat (3) @(posedge clk);
        #6;
        finish_run();
    end

endmodule